// File: doc/BRIEF.md
# Method Write Emitter

This block is the result-routing stage of a small command-processing engine. For each operation it gets an ALU result, a 3-bit routing mode and a destination register index. It then does some subset of four actions: write the register file, load the method address, pop a word from a parameter FIFO, and post an (address, data) write to a downstream register bus. The ALU and the instruction sequencer sit outside the block. The sequencer presents one operation at a time and holds it until `op_ready` is high at a clock edge.

Loading the method address loads two fields from the value: a 12-bit address and a 6-bit stride. Every posted write carries the current address, and the address then moves forward by the stride, wrapping within 4096. Sends can run back to back with a constant field offset and no extra instructions. Both outputs are registered. A register write shows as a one-cycle pulse, and a posted method write stays on the bus until the downstream accepts it.

Top module: `mthd_emit_unit`

## Requirements
- R1: After reset the register write strobe and the method write valid are low, and the method address and stride are both zero.
- R2: Mode value 1 writes `op_result` to register `op_dst`. It posts no method write and pops no parameter.
- R3: A register write aimed at index 0 is dropped, and `rf_we` stays low.
- R4: An address load (modes 2 and 5 load only) takes value bits 11:0 as the method address and value bits 17:12 as the stride. Mode 2 loads from `op_result`. Mode 5 loads from the popped parameter and also writes that parameter to `op_dst`.
- R5: Each method write carries the current address. The address then advances by the stride, modulo 4096.
- R6: Modes 0, 3 and 5 pop exactly one parameter, asserting `prm_ready` in the accepting cycle, and write it to `op_dst`. While `prm_valid` is low the operation waits with `op_ready` low and has no effect.
- R7: While a method write is pending and `mw_ready` is low, an operation that sends is held off with `op_ready` low, and `mw_addr`/`mw_data` stay stable.
- R8: Mode 6 writes `op_result` to `op_dst` and loads the address from it. It then pops a parameter and sends that parameter at the newly loaded address, after which the stride is applied.
- R9: Mode 7 writes `op_result` to `op_dst` and loads the address from it. It then sends `op_result` bits 17:12, zero-extended, at the newly loaded address.
- R10: Mode 3 sends the popped parameter and mode 4 sends `op_result`, both at the current address. Each also writes the sent value to `op_dst`.
- R11: Effects appear on the registered outputs in the cycle after the accepting edge. `rf_we` is high for that single cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation accepted at this edge |
| op_mode | input | 3 | Routing mode |
| op_dst | input | 3 | Destination register index |
| op_result | input | 32 | ALU result |
| prm_valid | input | 1 | Parameter FIFO not empty |
| prm_ready | output | 1 | Pop the parameter FIFO |
| prm_data | input | 32 | Parameter FIFO head |
| mw_valid | output | 1 | Method write pending |
| mw_ready | input | 1 | Downstream takes method write |
| mw_addr | output | 12 | Method write address |
| mw_data | output | 32 | Method write data |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | 3 | Register file write index |
| rf_data | output | 32 | Register file write data |

## Verification
Two functions share a cycle in modes 6 and 7: the address load and the send. The bench loads an address with a non-zero stride through one of these modes, checks that the posted write uses the new address and not the old one, and then uses a plain send to confirm that the stride was applied to the new base. A second overlap is the downstream draining a held write in the same edge that accepts the next send. The bench holds `mw_ready` low across a pending write, confirms that the next send is blocked and the bus is frozen, then raises ready and expects the new write in the very next cycle.

// File: rtl/mde_pkg.sv
package mde_pkg;
  typedef enum logic [2:0] {
    M_FETCH_STORE     = 3'd0,
    M_MOVE            = 3'd1,
    M_MOVE_LOAD       = 3'd2,
    M_FETCH_SEND      = 3'd3,
    M_MOVE_SEND       = 3'd4,
    M_FETCH_LOAD      = 3'd5,
    M_LOAD_FETCH_SEND = 3'd6,
    M_LOAD_SEND_HIGH  = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    SRC_RESULT = 2'd0,
    SRC_PARAM  = 2'd1,
    SRC_STRIDE = 2'd2
  } snd_src_e;

  typedef struct packed {
    logic     fetch;
    logic     reg_from_param;
    logic     load;
    logic     load_from_param;
    logic     send;
    snd_src_e send_src;
  } ctrl_t;
endpackage

// File: rtl/mde_decode.sv
module mde_decode
  import mde_pkg::*;
(
  input  logic [2:0] mode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{fetch: 1'b0, reg_from_param: 1'b0, load: 1'b0,
               load_from_param: 1'b0, send: 1'b0, send_src: SRC_RESULT};
    case (mode_e'(mode_i))
      M_FETCH_STORE: begin
        ctrl_o.fetch          = 1'b1;
        ctrl_o.reg_from_param = 1'b1;
      end
      M_MOVE: ;
      M_MOVE_LOAD: ctrl_o.load = 1'b1;
      M_FETCH_SEND: begin
        ctrl_o.fetch          = 1'b1;
        ctrl_o.reg_from_param = 1'b1;
        ctrl_o.send           = 1'b1;
        ctrl_o.send_src       = SRC_PARAM;
      end
      M_MOVE_SEND: ctrl_o.send = 1'b1;
      M_FETCH_LOAD: begin
        ctrl_o.fetch           = 1'b1;
        ctrl_o.reg_from_param  = 1'b1;
        ctrl_o.load            = 1'b1;
        ctrl_o.load_from_param = 1'b1;
      end
      M_LOAD_FETCH_SEND: begin
        ctrl_o.fetch    = 1'b1;
        ctrl_o.load     = 1'b1;
        ctrl_o.send     = 1'b1;
        ctrl_o.send_src = SRC_PARAM;
      end
      M_LOAD_SEND_HIGH: begin
        ctrl_o.load     = 1'b1;
        ctrl_o.send     = 1'b1;
        ctrl_o.send_src = SRC_STRIDE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mde_addr_reg.sv
module mde_addr_reg #(
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_en,
  input  logic [ADDR_W+INC_W-1:0] load_val,
  input  logic                    step_en,
  output logic [ADDR_W-1:0]       cur_addr_o
);
  localparam int LOAD_W = ADDR_W + INC_W;

  logic [ADDR_W-1:0] addr_q;
  logic [INC_W-1:0]  inc_q;
  logic [ADDR_W-1:0] base;
  logic [INC_W-1:0]  inc_sel;

  // A load in the same cycle as a send takes effect before the send.
  always_comb begin
    base    = load_en ? load_val[ADDR_W-1:0] : addr_q;
    inc_sel = load_en ? load_val[LOAD_W-1:ADDR_W] : inc_q;
  end

  assign cur_addr_o = base;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      inc_q  <= '0;
    end else if (load_en || step_en) begin
      inc_q  <= inc_sel;
      addr_q <= step_en ? base + ADDR_W'(inc_sel) : base;
    end
  end
endmodule

// File: rtl/mde_out_reg.sv
module mde_out_reg #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_en,
  input  logic [ADDR_W-1:0] snd_addr,
  input  logic [DATA_W-1:0] snd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mw_ready,
  output logic              slot_free,
  output logic              mw_valid,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [DATA_W-1:0] mw_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [DATA_W-1:0] rf_data
);
  assign slot_free = !mw_valid || mw_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
    end else if (send_en) begin
      mw_valid <= 1'b1;
      mw_addr  <= snd_addr;
      mw_data  <= snd_data;
    end else if (mw_ready) begin
      mw_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we   <= 1'b0;
      rf_idx  <= '0;
      rf_data <= '0;
    end else begin
      rf_we <= wr_en && (wr_idx != '0);
      if (wr_en) begin
        rf_idx  <= wr_idx;
        rf_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/mthd_emit_unit.sv
module mthd_emit_unit
  import mde_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_mode,
  input  logic [IDX_W-1:0]  op_dst,
  input  logic [DATA_W-1:0] op_result,
  input  logic              prm_valid,
  output logic              prm_ready,
  input  logic [DATA_W-1:0] prm_data,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [DATA_W-1:0] mw_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [DATA_W-1:0] rf_data
);
  localparam int LOAD_W = ADDR_W + INC_W;

  ctrl_t             ctrl;
  logic              slot_free;
  logic              accept;
  logic [LOAD_W-1:0] load_val;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] snd_data;
  logic [DATA_W-1:0] wr_data;

  mde_decode u_dec (
    .mode_i (op_mode),
    .ctrl_o (ctrl)
  );

  assign op_ready  = (!ctrl.fetch || prm_valid) && (!ctrl.send || slot_free);
  assign accept    = op_valid && op_ready;
  assign prm_ready = accept && ctrl.fetch;

  assign load_val = ctrl.load_from_param ? prm_data[LOAD_W-1:0] : op_result[LOAD_W-1:0];
  assign wr_data  = ctrl.reg_from_param ? prm_data : op_result;

  always_comb begin
    case (ctrl.send_src)
      SRC_PARAM:  snd_data = prm_data;
      SRC_STRIDE: snd_data = DATA_W'(op_result[LOAD_W-1:ADDR_W]);
      default:    snd_data = op_result;
    endcase
  end

  mde_addr_reg #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .load_en    (accept && ctrl.load),
    .load_val   (load_val),
    .step_en    (accept && ctrl.send),
    .cur_addr_o (cur_addr)
  );

  mde_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .send_en   (accept && ctrl.send),
    .snd_addr  (cur_addr),
    .snd_data  (snd_data),
    .wr_en     (accept),
    .wr_idx    (op_dst),
    .wr_data   (wr_data),
    .mw_ready  (mw_ready),
    .slot_free (slot_free),
    .mw_valid  (mw_valid),
    .mw_addr   (mw_addr),
    .mw_data   (mw_data),
    .rf_we     (rf_we),
    .rf_idx    (rf_idx),
    .rf_data   (rf_data)
  );
endmodule

// File: rtl/mthd_emit_chk.sv
module mthd_emit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              op_ready,
  input logic              prm_valid,
  input logic              prm_ready,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [ADDR_W-1:0] mw_addr,
  input logic [DATA_W-1:0] mw_data,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_idx
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  // R3
  zero_idx_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_idx != '0));

  // R6
  pop_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    prm_ready |-> (prm_valid && op_valid && op_ready));

  // R11
  rf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(op_valid && op_ready));

  // R11
  mw_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mw_valid) |-> $past(op_valid && op_ready));
endmodule

bind mthd_emit_unit mthd_emit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_mthd_emit_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .prm_valid (prm_valid),
  .prm_ready (prm_ready),
  .mw_valid  (mw_valid),
  .mw_ready  (mw_ready),
  .mw_addr   (mw_addr),
  .mw_data   (mw_data),
  .rf_we     (rf_we),
  .rf_idx    (rf_idx)
);

// File: tb/test_mthd_emit_unit.sv
module test_mthd_emit_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_mode = '0;
  logic [2:0]  op_dst = '0;
  logic [31:0] op_result = '0;
  logic        prm_valid = 1'b0;
  logic        prm_ready;
  logic [31:0] prm_data = '0;
  logic        mw_valid;
  logic        mw_ready = 1'b1;
  logic [11:0] mw_addr;
  logic [31:0] mw_data;
  logic        rf_we;
  logic [2:0]  rf_idx;
  logic [31:0] rf_data;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_addr = '0;
  logic [5:0]  m_inc = '0;
  logic        acc;
  logic        popped;

  always #10 clk = ~clk;

  mthd_emit_unit i_mthd_emit_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_mode(op_mode), .op_dst(op_dst), .op_result(op_result),
    .prm_valid(prm_valid), .prm_ready(prm_ready), .prm_data(prm_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic void m_load(input logic [31:0] v);
    m_addr = v[11:0];
    m_inc  = v[17:12];
  endfunction

  function automatic void m_step();
    m_addr = m_addr + 12'(m_inc);
  endfunction

  // Called at a falling edge; returns at the falling edge after the accepting rise.
  task automatic do_op(input logic [2:0] mode, input logic [2:0] dst,
                       input logic [31:0] res, input logic pv, input logic [31:0] pd);
    op_valid = 1'b1; op_mode = mode; op_dst = dst; op_result = res;
    prm_valid = pv; prm_data = pd;
    #1;
    acc    = op_ready;
    popped = prm_ready;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; prm_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rf_we", 32'(rf_we), 0);
    chk("R1 mw_valid", 32'(mw_valid), 0);
    do_op(3'd4, 3'd0, 32'h55, 1'b0, 0);
    chk("R1 send at reset address", 32'(mw_addr), 0);
    chk("R10 mode4 data", mw_data, 32'h55);
    chk("R3 index 0 dropped", 32'(rf_we), 0);
    m_step();
  endtask

  task automatic t_move();
    do_op(3'd1, 3'd3, 32'hDEAD, 1'b0, 0);
    chk("R2 rf_we", 32'(rf_we), 1);
    chk("R2 rf_idx", 32'(rf_idx), 3);
    chk("R2 rf_data", rf_data, 32'hDEAD);
    chk("R2 no send", 32'(mw_valid), 0);
    chk("R2 no pop", 32'(popped), 0);
    @(negedge clk);
    chk("R11 rf_we single pulse", 32'(rf_we), 0);
  endtask

  task automatic t_setaddr();
    do_op(3'd2, 3'd2, 32'h5100, 1'b0, 0);
    m_load(32'h5100);
    chk("R4 mode2 reg write", rf_data, 32'h5100);
    chk("R4 mode2 no send", 32'(mw_valid), 0);
    for (int k = 0; k < 2; k++) begin
      do_op(3'd4, 3'd1, 32'hA0 + 32'(k), 1'b0, 0);
      chk("R5 stride send addr", 32'(mw_addr), 32'(m_addr));
      chk("R10 mode4 data", mw_data, 32'hA0 + 32'(k));
      m_step();
    end
  endtask

  task automatic t_wrap();
    do_op(3'd2, 3'd2, 32'h3FFF0, 1'b0, 0);
    m_load(32'h3FFF0);
    do_op(3'd4, 3'd1, 32'h1, 1'b0, 0);
    chk("R5 addr before wrap", 32'(mw_addr), 32'hFF0);
    m_step();
    do_op(3'd4, 3'd1, 32'h2, 1'b0, 0);
    chk("R5 addr wraps", 32'(mw_addr), 32'h02F);
    m_step();
  endtask

  task automatic t_fetch();
    op_valid = 1'b1; op_mode = 3'd0; op_dst = 3'd4; op_result = 32'hBAD;
    prm_valid = 1'b0;
    #1;
    chk("R6 stall when FIFO empty", 32'(op_ready), 0);
    chk("R6 no pop when empty", 32'(prm_ready), 0);
    @(posedge clk); @(negedge clk);
    chk("R6 no write while stalled", 32'(rf_we), 0);
    do_op(3'd0, 3'd4, 32'hBAD, 1'b1, 32'h1234);
    chk("R6 pop", 32'(popped), 1);
    chk("R6 param written", rf_data, 32'h1234);
    chk("R6 idx", 32'(rf_idx), 4);
    do_op(3'd5, 3'd5, 32'h0, 1'b1, 32'h2040);
    m_load(32'h2040);
    chk("R4 mode5 reg gets param", rf_data, 32'h2040);
    chk("R4 mode5 no send", 32'(mw_valid), 0);
    do_op(3'd4, 3'd1, 32'h7, 1'b0, 0);
    chk("R4 param loaded address", 32'(mw_addr), 32'h040);
    m_step();
  endtask

  task automatic t_mode3();
    do_op(3'd3, 3'd6, 32'hFFFF, 1'b1, 32'h777);
    chk("R10 mode3 addr", 32'(mw_addr), 32'(m_addr));
    chk("R10 mode3 sends param", mw_data, 32'h777);
    chk("R10 mode3 reg", rf_data, 32'h777);
    m_step();
  endtask

  task automatic t_mode6();
    do_op(3'd6, 3'd7, 32'h1200, 1'b1, 32'h9);
    m_load(32'h1200);
    chk("R8 send at new address", 32'(mw_addr), 32'h200);
    chk("R8 sends param", mw_data, 32'h9);
    chk("R8 reg gets result", rf_data, 32'h1200);
    chk("R8 pop", 32'(popped), 1);
    m_step();
    do_op(3'd4, 3'd1, 32'h3, 1'b0, 0);
    chk("R8 stride after load", 32'(mw_addr), 32'h201);
    m_step();
  endtask

  task automatic t_mode7();
    do_op(3'd7, 3'd2, 32'h2A300, 1'b0, 0);
    m_load(32'h2A300);
    chk("R9 send at new address", 32'(mw_addr), 32'h300);
    chk("R9 sends stride field", mw_data, 32'h2A);
    chk("R9 reg gets result", rf_data, 32'h2A300);
    m_step();
    do_op(3'd4, 3'd1, 32'h4, 1'b0, 0);
    chk("R9 stride after load", 32'(mw_addr), 32'h32A);
    m_step();
  endtask

  task automatic t_stall();
    logic [11:0] first;
    @(negedge clk);
    mw_ready = 1'b0;
    first = m_addr;
    do_op(3'd4, 3'd1, 32'h11, 1'b0, 0);
    m_step();
    chk("R7 first send", 32'(mw_addr), 32'(first));
    op_valid = 1'b1; op_mode = 3'd4; op_dst = 3'd1; op_result = 32'h22;
    #1;
    chk("R7 send blocked", 32'(op_ready), 0);
    @(posedge clk); @(negedge clk);
    chk("R7 addr held", 32'(mw_addr), 32'(first));
    chk("R7 data held", mw_data, 32'h11);
    chk("R7 no write while blocked", 32'(rf_we), 0);
    mw_ready = 1'b1;
    #1;
    chk("R7 released", 32'(op_ready), 1);
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    chk("R7 next send addr", 32'(mw_addr), 32'(m_addr));
    chk("R7 next send data", mw_data, 32'h22);
    m_step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_move();
    t_setaddr();
    t_wrap();
    t_fetch();
    t_mode3();
    t_mode6();
    t_mode7();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule